// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block models the parallel programming port of an on-chip code store. A programmer holds the port in programming state with three enable pins and picks an operation with four mode-select pins. A rising edge on the active-low program strobe starts the chosen operation. Byte writes, lock writes and chip erase then run to completion on an internal cycle counter, and a ready output stays low for the whole of that time.

Reads are combinational from the current address. A code read returns the stored byte. While a byte write is in flight, a code read of the address being written shows bit 7 inverted, so software can poll for completion. A signature read returns fixed identification bytes. The array is a register memory. Its depth is set by `ADDR_W`: 13 gives the full 8K store, and the default is kept small. All delays are cycle counts set by parameters.

The three lock bits are write-only and stack in severity. Any set lock bit blocks byte programming. Lock 2 or lock 3 also hides the code contents. Lock 3 also withdraws the external-execution permit. Only a chip erase clears the lock bits.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `ext_exec_ok` is 1, no lock bit is set and every array byte reads FFh.
- R2: The port is active only when `prog_rst`=1, `psen_n`=0 and `pgm_en`=1. `mode_sel` is decoded with bit 3 as the first pin. The codes are: 0111 byte write, 0011 code read, 1111 lock 1, 1100 lock 2, 1010 lock 3, 1000 chip erase, 0000 signature read. When the port is inactive, or the code is not in this list, strobes are ignored and `dout` is FFh.
- R3: A rising edge of `strobe_n` in byte-write mode starts a write. `ready` goes low in the next cycle and stays low for exactly `WRITE_CYC` cycles.
- R4: While a byte write is busy, a code read of the address being written returns the written data with bit 7 inverted. Once `ready` is high again, the stored byte is returned on all bits.
- R5: A byte write stores the AND of the old byte and `din`. A byte that is not blank can therefore only lose 1 bits until the next erase.
- R6: A strobe edge that arrives while `ready` is low is ignored. It neither starts an operation nor extends the busy time.
- R7: In erase mode, a strobe held low for at least `ERASE_HOLD` cycles makes `ready` low for `ERASE_CYC` cycles, after which every byte reads FFh. A shorter low pulse does nothing.
- R8: A signature read returns 1Eh at address 030h, 52h at 031h, and at 032h either FFh (`HV_PART`=1) or 05h (`HV_PART`=0). Any other address returns FFh.
- R9: When any lock bit is set, a byte-write strobe is ignored: `ready` stays high and the array is unchanged.
- R10: Each lock write keeps `ready` low for `WRITE_CYC` cycles. When lock 2 or lock 3 is set, code reads return FFh. When lock 3 is set, `ext_exec_ok` is 0. Lock 1 alone leaves verify reads working.
- R11: A completed chip erase clears all lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_rst | input | 1 | Programming-state enable (high) |
| psen_n | input | 1 | Must be low for programming state |
| pgm_en | input | 1 | Program-enable level (high) |
| mode_sel | input | 4 | Mode-select pins, bit 3 first |
| strobe_n | input | 1 | Active-low program strobe |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data (code, polling or signature) |
| ready | output | 1 | 1 = idle, 0 = busy |
| ext_exec_ok | output | 1 | External execution permitted |

## Verification
The assertions check the local rules on every cycle:
- the busy counter starts when requested and then counts down by one each cycle without stalling;
- the strobe-low counter advances by one per low cycle;
- a byte write never sets a bit that the data held at 0;
- an erase fills the array with FFh;
- no byte write starts while any lock bit is set;
- a completed erase leaves the lock bits clear.

Only the bench scenarios can show the behaviour that spans many cycles:
- the exact busy length seen at the pins;
- polling values during a write;
- the threshold between a short erase pulse and a long one;
- strobes dropped while busy;
- the stacking of the three lock levels, observed through reads and the execution permit.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        M_NONE, M_WRITE, M_READ, M_LOCK1, M_LOCK2, M_LOCK3, M_ERASE, M_SIG
    } fp_mode_e;

    typedef enum logic [2:0] {
        OP_IDLE, OP_BYTE, OP_LOCK1, OP_LOCK2, OP_LOCK3, OP_ERASE
    } fp_op_e;

    typedef struct packed {
        fp_op_e     op;
        logic [7:0] data;
    } fp_pend_t;

    // bit 3 is the first select pin
    function automatic fp_mode_e decode_mode(input logic [3:0] s);
        case (s)
            4'b0111: return M_WRITE;
            4'b0011: return M_READ;
            4'b1111: return M_LOCK1;
            4'b1100: return M_LOCK2;
            4'b1010: return M_LOCK3;
            4'b1000: return M_ERASE;
            4'b0000: return M_SIG;
            default: return M_NONE;
        endcase
    endfunction

    function automatic logic [7:0] sig_byte(input logic [15:0] a, input logic hv);
        case (a)
            16'h0030: return 8'h1E;
            16'h0031: return 8'h52;
            16'h0032: return hv ? 8'hFF : 8'h05;
            default:  return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/fp_busy_timer.sv
module fp_busy_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= load;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);
    a_r6_busy_counts_down: assert property (@(posedge clk) disable iff (rst)
        busy && cnt != '0 |=> busy && cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/fp_strobe_mon.sv
module fp_strobe_mon #(
    parameter int HOLD   = 4000,
    parameter int HOLD_W = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic rise,
    output logic long_hold
);
    logic              strobe_q;
    logic [HOLD_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
            low_cnt  <= '0;
        end else begin
            strobe_q <= strobe_n;
            if (strobe_n)                         low_cnt <= '0;
            else if (low_cnt != HOLD_W'(HOLD))    low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rise      = strobe_n && !strobe_q;
    assign long_hold = low_cnt >= HOLD_W'(HOLD);

    a_r3_single_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
    a_r7_low_counts: assert property (@(posedge clk) disable iff (rst)
        !strobe_n && low_cnt < HOLD_W'(HOLD) |=> low_cnt == $past(low_cnt) + 1'b1);
endmodule

// File: rtl/fp_array.sv
module fp_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              erase,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[waddr] <= mem[waddr] & wdata;
        end
    end

    assign rdata = mem[raddr];

    a_r7_erase_fills: assert property (@(posedge clk) disable iff (rst)
        erase |=> mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF);
    a_r5_only_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en && !erase |=> (mem[$past(waddr)] & ~$past(wdata)) == 8'h00);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WRITE_CYC  = 1000,
    parameter int ERASE_CYC  = 20000,
    parameter int ERASE_HOLD = 4000,
    parameter bit HV_PART    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_rst,
    input  logic              psen_n,
    input  logic              pgm_en,
    input  logic [3:0]        mode_sel,
    input  logic              strobe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              ready,
    output logic              ext_exec_ok
);
    localparam int MAXC   = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int HOLD_W = $clog2(ERASE_HOLD + 1);

    logic              active, rise, long_hold, go, start, busy, done;
    logic [CNT_W-1:0]  load;
    fp_mode_e          mode;
    fp_op_e            next_op;
    fp_pend_t          pend;
    logic [ADDR_W-1:0] waddr;
    logic [2:0]        lock_q;   // [0]=lock 1, [1]=lock 2, [2]=lock 3
    logic [7:0]        rdata;

    assign active = prog_rst && !psen_n && pgm_en;
    assign mode   = active ? decode_mode(mode_sel) : M_NONE;
    assign go     = rise && active && !busy;

    fp_strobe_mon #(.HOLD(ERASE_HOLD), .HOLD_W(HOLD_W)) u_strobe (
        .clk(clk), .rst(rst), .strobe_n(strobe_n),
        .rise(rise), .long_hold(long_hold)
    );

    fp_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .start(start), .load(load),
        .busy(busy), .done(done)
    );

    fp_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst),
        .wr_en(done && pend.op == OP_BYTE),
        .erase(done && pend.op == OP_ERASE),
        .waddr(waddr), .wdata(pend.data),
        .raddr(addr), .rdata(rdata)
    );

    always_comb begin
        start   = 1'b0;
        load    = CNT_W'(WRITE_CYC - 1);
        next_op = OP_IDLE;
        case (mode)
            M_WRITE: if (lock_q == 3'b000) begin start = go; next_op = OP_BYTE; end
            M_LOCK1: begin start = go; next_op = OP_LOCK1; end
            M_LOCK2: begin start = go; next_op = OP_LOCK2; end
            M_LOCK3: begin start = go; next_op = OP_LOCK3; end
            M_ERASE: begin
                start   = go && long_hold;
                next_op = OP_ERASE;
                load    = CNT_W'(ERASE_CYC - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '{op: OP_IDLE, data: 8'hFF};
            waddr  <= '0;
            lock_q <= 3'b000;
        end else if (start) begin
            pend  <= '{op: next_op, data: din};
            waddr <= addr;
        end else if (done) begin
            case (pend.op)
                OP_LOCK1: lock_q[0] <= 1'b1;
                OP_LOCK2: lock_q[1] <= 1'b1;
                OP_LOCK3: lock_q[2] <= 1'b1;
                OP_ERASE: lock_q    <= 3'b000;
                default: ;
            endcase
            pend.op <= OP_IDLE;
        end
    end

    always_comb begin
        dout = 8'hFF;
        if (mode == M_READ) begin
            if (lock_q[1] || lock_q[2])
                dout = 8'hFF;
            else if (busy && pend.op == OP_BYTE && addr == waddr)
                dout = {~pend.data[7], pend.data[6:0]};
            else
                dout = rdata;
        end else if (mode == M_SIG) begin
            dout = sig_byte(16'(addr), HV_PART);
        end
    end

    assign ready       = !busy;
    assign ext_exec_ok = !lock_q[2];

    a_r9_locked_no_byte: assert property (@(posedge clk) disable iff (rst)
        lock_q != 3'b000 && !busy |=> !(busy && pend.op == OP_BYTE));
    a_r11_erase_unlocks: assert property (@(posedge clk) disable iff (rst)
        done && pend.op == OP_ERASE |=> lock_q == 3'b000);
endmodule

// File: tb/tb_flash_prog_ctrl.sv
module tb_flash_prog_ctrl;
    localparam int AW = 8;
    localparam int WC = 8;
    localparam int EC = 20;
    localparam int EH = 40;

    localparam logic [3:0] C_WRITE = 4'b0111, C_READ = 4'b0011, C_LOCK1 = 4'b1111,
                           C_LOCK2 = 4'b1100, C_LOCK3 = 4'b1010, C_ERASE = 4'b1000,
                           C_SIG = 4'b0000;

    logic clk = 1'b0, rst = 1'b1;
    logic prog_rst = 1'b1, psen_n = 1'b0, pgm_en = 1'b1, strobe_n = 1'b1;
    logic [3:0] mode_sel = C_READ;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = 8'hFF, dout;
    logic ready, ext_exec_ok;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC),
                      .ERASE_HOLD(EH), .HV_PART(1'b1)) dut (
        .clk(clk), .rst(rst), .prog_rst(prog_rst), .psen_n(psen_n), .pgm_en(pgm_en),
        .mode_sel(mode_sel), .strobe_n(strobe_n), .addr(addr), .din(din),
        .dout(dout), .ready(ready), .ext_exec_ok(ext_exec_ok)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] code, input int a, input logic [7:0] d, input int low);
        @(negedge clk);
        mode_sel = code; addr = AW'(a); din = d; strobe_n = 1'b0;
        repeat (low) @(negedge clk);
        strobe_n = 1'b1;
    endtask

    // busy length counted from the negedge after the strobe rise
    task automatic busy_len(output int n);
        n = 0;
        @(negedge clk);
        while (!ready && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [3:0] code, input int a, output logic [7:0] d);
        @(negedge clk);
        mode_sel = code; addr = AW'(a);
        #1 d = dout;
    endtask

    initial begin
        int n;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(C_READ, 5, d);
        check("R1 ready", int'(ready), 1);
        check("R1 exec", int'(ext_exec_ok), 1);
        for (int a = 0; a < 256; a++) begin
            rd(C_READ, a, d);
            check("R1 blank", d, 8'hFF);
        end

        // R8 signature
        rd(C_SIG, 8'h30, d); check("R8 sig30", d, 8'h1E);
        rd(C_SIG, 8'h31, d); check("R8 sig31", d, 8'h52);
        rd(C_SIG, 8'h32, d); check("R8 sig32", d, 8'hFF);
        rd(C_SIG, 8'h33, d); check("R8 sig33", d, 8'hFF);

        // R4 polling during the first write
        pulse(C_WRITE, 10, 8'hA5, 2);
        @(negedge clk);
        mode_sel = C_READ; addr = AW'(10);
        #1;
        check("R4 poll", dout, 8'h25);
        check("R3 busy low", int'(ready), 0);
        n = 1;
        @(negedge clk);
        while (!ready && n < 1000) begin n++; @(negedge clk); end
        check("R3 busy length", n, WC);
        #1 check("R4 true byte", dout, 8'hA5);

        // R3 R5 sweep of byte writes over every address
        for (int a = 0; a < 256; a++) begin
            if (a != 10) begin
                pulse(C_WRITE, a, pat(a), 2);
                busy_len(n);
                check("R3 busy length", n, WC);
            end
        end
        for (int a = 0; a < 256; a++) begin
            rd(C_READ, a, d);
            check("R5 stored", d, (a == 10) ? 8'hA5 : pat(a));
        end

        // R5 reprogram without erase gives AND
        pulse(C_WRITE, 3, 8'h0F, 2);
        busy_len(n);
        rd(C_READ, 3, d);
        check("R5 and", d, pat(3) & 8'h0F);

        // R6 strobe while busy is ignored
        pulse(C_WRITE, 20, 8'h00, 2);
        pulse(C_WRITE, 21, 8'h00, 2);
        busy_len(n);
        check("R6 busy not extended", n, WC - 3);
        @(negedge clk);
        check("R6 stays ready", int'(ready), 1);
        rd(C_READ, 21, d); check("R6 ignored", d, pat(21));
        rd(C_READ, 20, d); check("R6 first", d, 8'h00);

        // R2 inactive port and unknown code
        psen_n = 1'b1;
        pulse(C_WRITE, 30, 8'h00, 2);
        @(negedge clk);
        check("R2 inactive ready", int'(ready), 1);
        mode_sel = C_READ; #1;
        check("R2 inactive dout", dout, 8'hFF);
        psen_n = 1'b0;
        rd(C_READ, 30, d); check("R2 inactive no write", d, pat(30));
        pulse(4'b0101, 30, 8'h00, 2);
        @(negedge clk);
        check("R2 bad code", int'(ready), 1);
        #1 check("R2 bad code dout", dout, 8'hFF);
        rd(C_READ, 30, d); check("R2 bad code no write", d, pat(30));

        // R7 short erase pulse does nothing
        pulse(C_ERASE, 0, 8'hFF, 10);
        @(negedge clk);
        check("R7 short no busy", int'(ready), 1);
        rd(C_READ, 50, d); check("R7 short kept", d, pat(50));

        // R7 long erase
        pulse(C_ERASE, 0, 8'hFF, 60);
        busy_len(n);
        check("R7 erase busy", n, EC);
        for (int a = 0; a < 256; a++) begin
            rd(C_READ, a, d);
            check("R7 erased", d, 8'hFF);
        end

        // R9 R10 locks
        pulse(C_WRITE, 7, 8'h5A, 2); busy_len(n);
        pulse(C_LOCK1, 0, 8'hFF, 2); busy_len(n);
        check("R10 lock busy", n, WC);
        pulse(C_WRITE, 7, 8'h00, 2);
        @(negedge clk);
        check("R9 no busy", int'(ready), 1);
        rd(C_READ, 7, d); check("R9 unchanged", d, 8'h5A);
        check("R10 exec lock1", int'(ext_exec_ok), 1);
        pulse(C_LOCK2, 0, 8'hFF, 2); busy_len(n);
        check("R10 lock busy", n, WC);
        rd(C_READ, 7, d); check("R10 verify hidden", d, 8'hFF);
        rd(C_SIG, 8'h31, d); check("R8 sig under lock", d, 8'h52);
        check("R10 exec lock2", int'(ext_exec_ok), 1);
        pulse(C_LOCK3, 0, 8'hFF, 2); busy_len(n);
        check("R10 exec lock3", int'(ext_exec_ok), 0);

        // R11 erase clears locks
        pulse(C_ERASE, 0, 8'hFF, 60); busy_len(n);
        check("R11 exec", int'(ext_exec_ok), 1);
        pulse(C_WRITE, 7, 8'h33, 2); busy_len(n);
        check("R11 write allowed", n, WC);
        rd(C_READ, 7, d); check("R11 readable", d, 8'h33);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule